// File: doc/BRIEF.md
# Descriptor Ring Index Manager

This block holds the bookkeeping for one circular descriptor ring shared between a software producer and a hardware consumer. Software programs a base address and a ring size and moves the head index forward as it posts descriptors. Hardware consumes descriptors and reports each completion on a one-cycle strobe, which moves the tail index forward. The block derives the pending count, the empty and full flags, and the byte address of the descriptor that hardware should process next.

Head and tail both wrap at the ring size. Illegal requests are refused and recorded in a sticky error flag. An illegal request is a size that is not a power of two in the supported range, a head value outside the ring, or a head value that would overrun the tail. Reprogramming the base or the size puts both indices back to zero, and so does a reset request on the control port. All state is registered. Every output follows from the registers, so a write is visible on the outputs one cycle after the clock edge that accepts it.

Top module: `desc_ring_idx`

## Requirements
- R1: After reset, head and tail are 0, the base is 0, the size is 2, the error flag is 0 and the ring reports empty.
- R2: A size write is accepted only for a power of two from 2 to 2^IDX_W (65536 by default). When accepted, it updates the size and clears head and tail. Any other value leaves the size, head and tail unchanged and sets the error flag.
- R3: A base write stores the value with its three low bits forced to 0 and clears head and tail.
- R4: Pending equals (head − tail) mod size. Empty is asserted when pending is 0, and full is asserted when pending equals size − 1.
- R5: A completion strobe while pending is nonzero moves the tail up by one, modulo the size. A strobe while the ring is empty is ignored.
- R6: A head write is accepted when its value is below the size and the forward distance (value − head) mod size is no greater than the free slots, size − 1 − pending.
- R7: A refused head write leaves the head unchanged and sets the error flag.
- R8: A control write with bit 0 set clears head, tail and the error flag, and any size, base or head write in the same cycle is ignored. A control write with bit 0 clear has no effect.
- R9: The next-descriptor address equals base + tail × 2^STRIDE_LOG2 (32-byte stride by default).
- R10: The error flag remains set until a ring reset clears it.
- R11: In a cycle where the indices are cleared, a head write and a completion strobe in that same cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr | input | 1 | Base address write strobe |
| base_wdata | input | ADDR_W | Base address write value |
| size_wr | input | 1 | Ring size write strobe |
| size_wdata | input | REG_W | Ring size write value (entries) |
| head_wr | input | 1 | Head index write strobe |
| head_wdata | input | REG_W | Head index write value |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | REG_W | Control value; bit 0 requests a ring reset |
| done_i | input | 1 | Hardware completion strobe (tail advance) |
| base_o | output | ADDR_W | Current base address |
| size_o | output | REG_W | Current ring size |
| head_o | output | IDX_W | Current head index |
| tail_o | output | IDX_W | Current tail index |
| pending_o | output | IDX_W | Descriptors pending for hardware |
| empty_o | output | 1 | Ring empty |
| full_o | output | 1 | Ring full |
| next_addr_o | output | ADDR_W | Address of the next descriptor for hardware |
| err_o | output | 1 | Sticky error flag |

## Verification
Every register updates on the edge that accepts a strobe. Every status output is combinational from those registers. As a result, each result is due exactly one cycle after the stimulus: head, tail, size, base, error, pending, the flags and the next address all settle before the following falling edge. The bench drives each strobe for a single cycle starting at a falling edge and samples at the next falling edge, so no result is read early or late. An 8-entry ring is swept over every tail position, every pending count and every head write value, and every power-of-two size and several illegal sizes are also covered.

// File: rtl/ring_pkg.sv
// Shared definitions for the descriptor ring index manager.
// Assumes: control bit positions are fixed by software convention.
package ring_pkg;
    localparam int unsigned CTRL_RST_BIT = 0;

    // Per-cycle events that the configuration stage hands to the index stage.
    typedef struct packed {
        logic idx_clr;   // clear head and tail this cycle
        logic err_clr;   // clear the sticky error flag this cycle
        logic size_bad;  // an illegal size write was refused this cycle
    } ring_ev_t;
endpackage

// File: rtl/ring_cfg.sv
// Configuration registers: base address and ring size.
// Checks that each size write is legal, forces the base to 8-byte alignment,
// and turns register writes into clear and error events for the index stage.
// Assumes: a ring reset in a cycle overrides any base or size write.
module ring_cfg
    import ring_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 16,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              size_wr,
    input  logic [REG_W-1:0]  size_wdata,
    input  logic              ctrl_wr,
    input  logic [REG_W-1:0]  ctrl_wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [IDX_W:0]    size_q,
    output ring_ev_t          ev
);
    localparam int SIZE_W = IDX_W + 1;
    localparam logic [REG_W-1:0] MAX_SIZE = REG_W'(1) << IDX_W;
    localparam logic [REG_W-1:0] MIN_SIZE = REG_W'(2);

    logic ring_rst;
    logic size_legal;
    logic size_take;
    logic base_take;

    // Decode the ring reset request from the control write.
    assign ring_rst = ctrl_wr & ctrl_wdata[CTRL_RST_BIT];

    // A size is legal when it is a power of two inside [MIN_SIZE, MAX_SIZE].
    assign size_legal = (size_wdata != '0)
                      && ((size_wdata & (size_wdata - REG_W'(1))) == '0)
                      && (size_wdata >= MIN_SIZE) && (size_wdata <= MAX_SIZE);

    assign size_take = size_wr & size_legal & ~ring_rst;
    assign base_take = base_wr & ~ring_rst;

    // Form the events for the index stage.
    assign ev.idx_clr  = ring_rst | size_take | base_take;
    assign ev.err_clr  = ring_rst;
    assign ev.size_bad = size_wr & ~size_legal & ~ring_rst;

    // Hold the base and size registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= SIZE_W'(2);
        end else begin
            if (base_take) base_q <= {base_wdata[ADDR_W-1:3], 3'b000};
            if (size_take) size_q <= size_wdata[SIZE_W-1:0];
        end
    end

    // An accepted size write shows up in the size register on the next cycle.
    assert_size_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && size_legal && !ring_rst) |=> (size_q == $past(size_wdata[SIZE_W-1:0])));

    // A refused size write leaves the size register unchanged.
    assert_size_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && !size_legal && !ring_rst) |=> $stable(size_q));

    // The stored size is always a power of two, at least 2.
    assert_size_pow2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(size_q) == 1) && (size_q >= SIZE_W'(2)));

    // A ring reset blocks a base write made in the same cycle.
    assert_rst_blocks_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_rst && base_wr) |=> $stable(base_q));
endmodule

// File: rtl/ring_idx_core.sv
// Head and tail indices with the sticky error flag.
// Decides whether each head write may go ahead, advances the tail on
// completions, and derives pending, empty and full.
// Assumes: mask equals size-1 for a power-of-two size; a clear event wins.
module ring_idx_core
    import ring_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] mask,
    input  ring_ev_t         ev,
    input  logic             head_wr,
    input  logic [REG_W-1:0] head_wdata,
    input  logic             done_i,
    output logic [IDX_W-1:0] head_q,
    output logic [IDX_W-1:0] tail_q,
    output logic [IDX_W-1:0] pending,
    output logic             empty,
    output logic             full,
    output logic             err_q
);
    logic [IDX_W-1:0] free_slots;
    logic [IDX_W-1:0] advance;
    logic             in_range;
    logic             head_ok;
    logic             head_take;
    logic             head_rej;
    logic             tail_take;

    // Derive occupancy from the two indices.
    assign pending    = (head_q - tail_q) & mask;
    assign free_slots = mask - pending;
    assign empty      = (pending == '0);
    assign full       = (pending == mask);

    // A head write must stay inside the ring and must not overrun the tail.
    assign in_range  = (head_wdata <= {{(REG_W-IDX_W){1'b0}}, mask});
    assign advance   = (head_wdata[IDX_W-1:0] - head_q) & mask;
    assign head_ok   = in_range && (advance <= free_slots);
    assign head_take = head_wr & head_ok & ~ev.idx_clr;
    assign head_rej  = head_wr & ~head_ok & ~ev.idx_clr;
    assign tail_take = done_i & ~empty & ~ev.idx_clr;

    // Update head and tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (ev.idx_clr) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (head_take) head_q <= head_wdata[IDX_W-1:0];
            if (tail_take) tail_q <= (tail_q + IDX_W'(1)) & mask;
        end
    end

    // Update the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                        err_q <= 1'b0;
        else if (ev.err_clr)               err_q <= 1'b0;
        else if (head_rej || ev.size_bad)  err_q <= 1'b1;
    end

    // The head always lies inside the ring.
    assert_head_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((head_q & ~mask) == '0));

    // A refused head write keeps the old head and raises the error flag.
    assert_head_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (head_wr && !head_ok && !ev.idx_clr) |=> ($stable(head_q) && err_q));

    // A completion strobe on an empty ring leaves the tail unchanged.
    assert_empty_done_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !ev.idx_clr) |=> $stable(tail_q));

    // A clear event zeroes both indices, whatever else happens that cycle.
    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev.idx_clr |=> (head_q == '0 && tail_q == '0));

    // The error flag stays set until a ring reset.
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !ev.err_clr) |=> err_q);
endmodule

// File: rtl/ring_addr_gen.sv
// Next-descriptor address: base plus tail times the descriptor stride.
// Assumes: the stride is a power of two, 2**STRIDE_LOG2 bytes.
module ring_addr_gen #(
    parameter int ADDR_W      = 64,
    parameter int IDX_W       = 16,
    parameter int STRIDE_LOG2 = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  tail,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] offset;

    // Scale the tail index by the stride, choosing the form at elaboration time.
    generate
        if (STRIDE_LOG2 == 0) begin : g_unit
            assign offset = ADDR_W'(tail);
        end else begin : g_scaled
            assign offset = ADDR_W'(tail) << STRIDE_LOG2;
        end
    endgenerate

    // Add the scaled offset to the base.
    assign next_addr = base + offset;
endmodule

// File: rtl/desc_ring_idx.sv
// Top level of the descriptor ring index manager.
// Connects the configuration registers, the index core and the address generator.
// Assumes: every write strobe lasts one cycle; outputs follow the registers.
module desc_ring_idx
    import ring_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int IDX_W       = 16,
    parameter int REG_W       = 32,
    parameter int STRIDE_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              size_wr,
    input  logic [REG_W-1:0]  size_wdata,
    input  logic              head_wr,
    input  logic [REG_W-1:0]  head_wdata,
    input  logic              ctrl_wr,
    input  logic [REG_W-1:0]  ctrl_wdata,
    input  logic              done_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [REG_W-1:0]  size_o,
    output logic [IDX_W-1:0]  head_o,
    output logic [IDX_W-1:0]  tail_o,
    output logic [IDX_W-1:0]  pending_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic              err_o
);
    localparam int SIZE_W = IDX_W + 1;

    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] size_m1;
    logic [IDX_W-1:0]  mask;
    ring_ev_t          ev;

    // Derive the wrap mask from the stored size.
    assign size_m1 = size_q - SIZE_W'(1);
    assign mask    = size_m1[IDX_W-1:0];
    assign size_o  = REG_W'(size_q);

    ring_cfg #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .REG_W(REG_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .size_wr    (size_wr),
        .size_wdata (size_wdata),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .base_q     (base_o),
        .size_q     (size_q),
        .ev         (ev)
    );

    ring_idx_core #(.IDX_W(IDX_W), .REG_W(REG_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask       (mask),
        .ev         (ev),
        .head_wr    (head_wr),
        .head_wdata (head_wdata),
        .done_i     (done_i),
        .head_q     (head_o),
        .tail_q     (tail_o),
        .pending    (pending_o),
        .empty      (empty_o),
        .full       (full_o),
        .err_q      (err_o)
    );

    ring_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .STRIDE_LOG2(STRIDE_LOG2)) u_addr (
        .base      (base_o),
        .tail      (tail_o),
        .next_addr (next_addr_o)
    );

    // A base write without a ring reset always clears both indices.
    assert_base_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !(ctrl_wr && ctrl_wdata[CTRL_RST_BIT])) |=> (head_o == '0 && tail_o == '0));
endmodule

// File: tb/desc_ring_idx_tb.sv
`timescale 1ns/1ps
module desc_ring_idx_tb;
    localparam int ADDR_W = 64;
    localparam int IDX_W  = 16;
    localparam int REG_W  = 32;
    localparam int STRIDE = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              base_wr = 1'b0;
    logic [ADDR_W-1:0] base_wdata = '0;
    logic              size_wr = 1'b0;
    logic [REG_W-1:0]  size_wdata = '0;
    logic              head_wr = 1'b0;
    logic [REG_W-1:0]  head_wdata = '0;
    logic              ctrl_wr = 1'b0;
    logic [REG_W-1:0]  ctrl_wdata = '0;
    logic              done_i = 1'b0;
    logic [ADDR_W-1:0] base_o;
    logic [REG_W-1:0]  size_o;
    logic [IDX_W-1:0]  head_o;
    logic [IDX_W-1:0]  tail_o;
    logic [IDX_W-1:0]  pending_o;
    logic              empty_o;
    logic              full_o;
    logic [ADDR_W-1:0] next_addr_o;
    logic              err_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    desc_ring_idx u_dut (
        .clk(clk), .rst_n(rst_n),
        .base_wr(base_wr), .base_wdata(base_wdata),
        .size_wr(size_wr), .size_wdata(size_wdata),
        .head_wr(head_wr), .head_wdata(head_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .done_i(done_i),
        .base_o(base_o), .size_o(size_o), .head_o(head_o), .tail_o(tail_o),
        .pending_o(pending_o), .empty_o(empty_o), .full_o(full_o),
        .next_addr_o(next_addr_o), .err_o(err_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: the edge takes effect, then sample at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_head(input logic [31:0] v);
        head_wr = 1'b1; head_wdata = v; tick(); head_wr = 1'b0;
    endtask

    task automatic wr_size(input logic [31:0] v);
        size_wr = 1'b1; size_wdata = v; tick(); size_wr = 1'b0;
    endtask

    task automatic wr_base(input logic [63:0] v);
        base_wr = 1'b1; base_wdata = v; tick(); base_wr = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v; tick(); ctrl_wr = 1'b0;
    endtask

    task automatic pulse_done();
        done_i = 1'b1; tick(); done_i = 1'b0;
    endtask

    // Put an 8-entry ring at tail t with p descriptors pending.
    task automatic setup(input int t, input int p);
        wr_ctrl(32'h1);
        wr_head(32'(t));
        for (int i = 0; i < t; i++) pulse_done();
        wr_head(32'((t + p) % 8));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "head", 64'(head_o), 64'd0);
        chk("R1", "tail", 64'(tail_o), 64'd0);
        chk("R1", "base", base_o, 64'd0);
        chk("R1", "size", 64'(size_o), 64'd2);
        chk("R1", "err", 64'(err_o), 64'd0);
        chk("R1", "empty", 64'(empty_o), 64'd1);

        // R2: every power-of-two size from 1 to 2^17, plus some non powers of two
        for (int k = 0; k <= 17; k++) begin
            logic [31:0] prev;
            bit legal;
            wr_ctrl(32'h1);
            prev = size_o;
            legal = (k >= 1) && (k <= 16);
            wr_size(32'h1 << k);
            chk("R2", "size pow2", 64'(size_o), legal ? 64'(32'h1 << k) : 64'(prev));
            chk("R2", "err pow2", 64'(err_o), legal ? 64'd0 : 64'd1);
        end
        wr_ctrl(32'h1);
        wr_size(32'd16);
        wr_head(32'd5);
        foreach (size_wdata[i]) if (i < 3) begin
            logic [31:0] bad;
            bad = (i == 0) ? 32'd0 : (i == 1) ? 32'd12 : 32'd65537;
            wr_size(bad);
            chk("R2", "illegal size kept", 64'(size_o), 64'd16);
            chk("R2", "illegal size head kept", 64'(head_o), 64'd5);
            chk("R2", "illegal size err", 64'(err_o), 64'd1);
        end
        wr_size(32'd16);
        chk("R2", "legal size clears head", 64'(head_o), 64'd0);

        // R10: the error flag survives base and size writes; a ring reset clears it
        wr_base(64'h100);
        chk("R10", "err sticky after base", 64'(err_o), 64'd1);
        wr_ctrl(32'h2);
        chk("R8", "ctrl bit0 clear no effect", 64'(err_o), 64'd1);
        wr_ctrl(32'h1);
        chk("R10", "err cleared by ring reset", 64'(err_o), 64'd0);

        // R3 / R9: base alignment, index clear, next address
        wr_size(32'd8);
        wr_head(32'd4);
        pulse_done(); pulse_done();
        chk("R9", "next addr", next_addr_o, 64'h100 + 64'(2 * STRIDE));
        wr_base(64'h1234_5677);
        chk("R3", "base aligned", base_o, 64'h1234_5670);
        chk("R3", "head cleared", 64'(head_o), 64'd0);
        chk("R3", "tail cleared", 64'(tail_o), 64'd0);
        chk("R9", "next addr at tail 0", next_addr_o, 64'h1234_5670);

        // R6: a head value outside the ring is refused
        wr_ctrl(32'h1);
        wr_head(32'd8);
        chk("R6", "out of range head", 64'(head_o), 64'd0);
        chk("R7", "out of range err", 64'(err_o), 64'd1);

        // R11 / R8: a ring reset overrides head write, size write and completion
        wr_ctrl(32'h1);
        wr_head(32'd3);
        ctrl_wr = 1'b1; ctrl_wdata = 32'h1; head_wr = 1'b1; head_wdata = 32'd6;
        size_wr = 1'b1; size_wdata = 32'd4; done_i = 1'b1;
        tick();
        ctrl_wr = 1'b0; head_wr = 1'b0; size_wr = 1'b0; done_i = 1'b0;
        chk("R11", "head after reset+write", 64'(head_o), 64'd0);
        chk("R11", "tail after reset+done", 64'(tail_o), 64'd0);
        chk("R8", "size ignored under reset", 64'(size_o), 64'd8);

        // R11: a base write in the same cycle as a completion
        wr_head(32'd3);
        base_wr = 1'b1; base_wdata = 64'h200; done_i = 1'b1;
        tick();
        base_wr = 1'b0; done_i = 1'b0;
        chk("R11", "tail after base+done", 64'(tail_o), 64'd0);
        chk("R11", "head after base+done", 64'(head_o), 64'd0);

        // R4 / R5 / R9: sweep every tail position and pending count on an 8-entry ring
        for (int t = 0; t < 8; t++) begin
            for (int p = 0; p < 8; p++) begin
                int tn;
                setup(t, p);
                chk("R4", "pending", 64'(pending_o), 64'(p));
                chk("R4", "empty", 64'(empty_o), 64'(p == 0));
                chk("R4", "full", 64'(full_o), 64'(p == 7));
                chk("R9", "next addr sweep", next_addr_o, 64'h200 + 64'(t * STRIDE));
                pulse_done();
                tn = (p > 0) ? (t + 1) % 8 : t;
                chk("R5", "tail after done", 64'(tail_o), 64'(tn));
                chk("R5", "pending after done", 64'(pending_o), 64'((p > 0) ? p - 1 : 0));
            end
        end

        // R6 / R7: every head write value from every tail and pending state
        for (int t = 0; t < 8; t++) begin
            for (int p = 0; p < 8; p++) begin
                for (int v = 0; v < 8; v++) begin
                    int h;
                    int adv;
                    bit ok;
                    setup(t, p);
                    h = (t + p) % 8;
                    adv = (v - h + 8) % 8;
                    ok = (adv <= 7 - p);
                    wr_head(32'(v));
                    chk(ok ? "R6" : "R7", "head write", 64'(head_o), 64'(ok ? v : h));
                    chk("R7", "err after head write", 64'(err_o), 64'(!ok));
                end
            end
        end

        // R4 / R6: the largest ring fills completely and wraps
        wr_ctrl(32'h1);
        wr_size(32'd65536);
        wr_head(32'd65535);
        chk("R4", "max ring full", 64'(full_o), 64'd1);
        chk("R4", "max ring pending", 64'(pending_o), 64'd65535);
        pulse_done();
        chk("R5", "max ring tail", 64'(tail_o), 64'd1);
        wr_head(32'd0);
        chk("R6", "max ring head wraps", 64'(head_o), 64'd0);
        chk("R4", "max ring pending after wrap", 64'(pending_o), 64'd65535);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule